// File: doc/BRIEF.md
# Random Number CSR Cache Unit

This block supplies a processor core with two read-only random-number control registers and one write-only trigger register. The high-quality register is served from a one-word cache. The cache is filled from a slow external entropy source through a request/acknowledge handshake. When the core reads this register while the cache is empty, the block stalls the core until a fresh word arrives.

The fast register returns the state of a local 32-bit linear-feedback shift register. A read of the fast register never stalls, and each read advances the generator.

The trigger register lets software start a cache fill ahead of time, so that a later read of the high-quality register completes without waiting. Addresses are 12 bits: 0xFC0 selects the high-quality word, 0xFC1 the fast word, and 0x7D8 the fill trigger.

Top module: `rng_csr_unit`

## Requirements
- R1: After reset the cache is empty, `ent_req_o` is low, and with no access in progress `csr_stall_o` is low and `csr_rdata_o` is zero.
- R2: A read of 0xFC0 while the cache is empty and no fill is outstanding raises `csr_stall_o` in the same cycle and raises `ent_req_o` from the next cycle.
- R3: `ent_req_o` stays high until a cycle with `ent_ack_i` high, and drops in the cycle after that. A read of 0xFC0 that is stalled waiting on the fill completes in the acknowledge cycle, with `csr_rdata_o` equal to `ent_data_i`.
- R4: Any write to 0x7D8 while the cache is empty and idle raises `ent_req_o` from the next cycle. The word acknowledged is stored, and a later read of 0xFC0 returns it in the same cycle without a stall.
- R5: Every completed read of 0xFC0 empties the cache, so the next read of 0xFC0 stalls again for a new word.
- R6: A write to 0x7D8 while a fill is outstanding, or while the cache is full, issues no further request. Each fill produces exactly one acknowledged request.
- R7: A read of 0x7D8 returns zero without a stall.
- R8: A read of 0xFC1 never stalls. It returns the generator state, which starts at 0x1D872B41 after reset. After each such read the state becomes (s >> 1) XOR (0xA3000000 when bit 0 of s is 1, else 0).
- R9: `ent_ack_i` has no effect while `ent_req_o` is low: the word on `ent_data_i` is not stored, and the cache stays empty.
- R10: A read of any other address returns zero without a stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_req_i | input | 1 | Register access valid; held while stalled |
| csr_we_i | input | 1 | 1 = write, 0 = read |
| csr_addr_i | input | 12 | Register address |
| csr_rdata_o | output | 32 | Read data, valid in a cycle without stall |
| csr_stall_o | output | 1 | Core must hold the access this cycle |
| ent_req_o | output | 1 | Request for one entropy word |
| ent_ack_i | input | 1 | Entropy word delivered this cycle |
| ent_data_i | input | 32 | Entropy word, valid with acknowledge |

## Verification
Reads of the fast register, of the trigger register and of unmapped addresses, as well as hits in a full cache, complete in the cycle they are presented. A read that misses completes in the cycle the acknowledge arrives, so the number of stalled cycles it shows equals the number of cycles the responder takes to acknowledge. The request line rises one edge after the miss or trigger and falls one edge after the acknowledge.

The driver pushes each expected word, with its exact count of stalled cycles, into a queue. The monitor samples at the falling edge, counts stalled cycles of the held access, and pops and compares when the access completes. Checks on request behaviour are taken a whole number of cycles after the stimulus, once the registered request has settled.

// File: rtl/rng_csr_pkg.sv
package rng_csr_pkg;
  localparam int unsigned CSR_AW = 12;
  localparam int unsigned CSR_DW = 32;
  localparam logic [CSR_AW-1:0] ADDR_HQ_RND  = 12'hFC0;
  localparam logic [CSR_AW-1:0] ADDR_FAST_RND = 12'hFC1;
  localparam logic [CSR_AW-1:0] ADDR_PREFILL = 12'h7D8;
  localparam logic [CSR_DW-1:0] PRNG_SEED  = 32'h1D87_2B41;
  localparam logic [CSR_DW-1:0] PRNG_TAPS  = 32'hA300_0000;
endpackage

// File: rtl/rng_csr_decode.sv
module rng_csr_decode #(
  parameter int unsigned AW = 12,
  parameter logic [AW-1:0] HQ_ADDR   = '0,
  parameter logic [AW-1:0] FAST_ADDR = '0,
  parameter logic [AW-1:0] PREF_ADDR = '0
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic          hq_rd_o,
  output logic          fast_rd_o,
  output logic          pref_wr_o
);
  logic rd, wr;

  always_comb begin
    rd        = req_i & ~we_i;
    wr        = req_i & we_i;
    hq_rd_o   = rd & (addr_i == HQ_ADDR);
    fast_rd_o = rd & (addr_i == FAST_ADDR);
    pref_wr_o = wr & (addr_i == PREF_ADDR);
  end
endmodule

// File: rtl/rng_entropy_cache.sv
module rng_entropy_cache #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hq_rd_i,
  input  logic          pref_wr_i,
  input  logic          ent_ack_i,
  input  logic [DW-1:0] ent_data_i,
  output logic          ent_req_o,
  output logic [DW-1:0] hq_rdata_o,
  output logic          hq_stall_o
);
  logic          valid_q, valid_d;
  logic          pend_q, pend_d;
  logic [DW-1:0] word_q, word_d;
  logic          word_en;
  logic          ack_take, fill_start;

  // next-state logic
  always_comb begin
    ack_take   = pend_q & ent_ack_i;
    fill_start = ~valid_q & ~pend_q & (pref_wr_i | hq_rd_i);
    hq_stall_o = hq_rd_i & ~valid_q & ~ack_take;
    hq_rdata_o = valid_q ? word_q : ent_data_i;

    pend_d = pend_q;
    if (ack_take)        pend_d = 1'b0;
    else if (fill_start) pend_d = 1'b1;

    valid_d = valid_q;
    if (hq_rd_i && valid_q)        valid_d = 1'b0;
    else if (ack_take && !hq_rd_i) valid_d = 1'b1;

    // store only when the acknowledged word is not consumed directly
    word_en = ack_take & ~hq_rd_i;
    word_d  = ent_data_i;
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign ent_req_o = pend_q;
endmodule

// File: rtl/rng_lfsr_prng.sv
module rng_lfsr_prng #(
  parameter int unsigned   W    = 32,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAPS = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d, shift_n;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      assign shift_n[i] = TAPS[i] & state_q[0];
    end else begin : g_mid
      assign shift_n[i] = state_q[i+1] ^ (TAPS[i] & state_q[0]);
    end
  end

  always_comb begin
    state_d = step_i ? shift_n : state_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/rng_csr_unit.sv
module rng_csr_unit
  import rng_csr_pkg::*;
#(
  parameter int unsigned   AW         = CSR_AW,
  parameter int unsigned   DW         = CSR_DW,
  parameter logic [DW-1:0] SEED       = PRNG_SEED,
  parameter logic [DW-1:0] TAPS       = PRNG_TAPS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          csr_req_i,
  input  logic          csr_we_i,
  input  logic [AW-1:0] csr_addr_i,
  output logic [DW-1:0] csr_rdata_o,
  output logic          csr_stall_o,
  output logic          ent_req_o,
  input  logic          ent_ack_i,
  input  logic [DW-1:0] ent_data_i
);
  logic          hq_rd, fast_rd, pref_wr;
  logic [DW-1:0] hq_data, prng_word;
  logic          hq_stall;

  rng_csr_decode #(
    .AW        (AW),
    .HQ_ADDR   (AW'(ADDR_HQ_RND)),
    .FAST_ADDR (AW'(ADDR_FAST_RND)),
    .PREF_ADDR (AW'(ADDR_PREFILL))
  ) i_decode (
    .req_i     (csr_req_i),
    .we_i      (csr_we_i),
    .addr_i    (csr_addr_i),
    .hq_rd_o   (hq_rd),
    .fast_rd_o (fast_rd),
    .pref_wr_o (pref_wr)
  );

  rng_entropy_cache #(.DW(DW)) i_cache (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hq_rd_i    (hq_rd),
    .pref_wr_i  (pref_wr),
    .ent_ack_i  (ent_ack_i),
    .ent_data_i (ent_data_i),
    .ent_req_o  (ent_req_o),
    .hq_rdata_o (hq_data),
    .hq_stall_o (hq_stall)
  );

  rng_lfsr_prng #(.W(DW), .SEED(SEED), .TAPS(TAPS)) i_prng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (fast_rd),
    .state_o (prng_word)
  );

  always_comb begin
    csr_rdata_o = '0;
    if (hq_rd)        csr_rdata_o = hq_data;
    else if (fast_rd) csr_rdata_o = prng_word;
    csr_stall_o = hq_stall;
  end
endmodule

// File: rtl/rng_csr_unit_chk.sv
module rng_csr_unit_chk #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          csr_req_i,
  input logic          csr_we_i,
  input logic [AW-1:0] csr_addr_i,
  input logic [DW-1:0] csr_rdata_o,
  input logic          csr_stall_o,
  input logic          ent_req_o,
  input logic          ent_ack_i,
  input logic [DW-1:0] ent_data_i
);
  logic rd_hq, rd_fast, rd_pref;
  assign rd_hq   = csr_req_i && !csr_we_i && csr_addr_i == AW'(12'hFC0);
  assign rd_fast = csr_req_i && !csr_we_i && csr_addr_i == AW'(12'hFC1);
  assign rd_pref = csr_req_i && !csr_we_i && csr_addr_i == AW'(12'h7D8);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_req_i |-> (!csr_stall_o && csr_rdata_o == '0));

  p_stall_source_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_stall_o |-> rd_hq);

  p_miss_requests_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hq && csr_stall_o && !ent_req_o) |=> ent_req_o);

  p_req_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_req_o && !ent_ack_i) |=> ent_req_o);

  p_release_on_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hq && ent_req_o && ent_ack_i) |-> (!csr_stall_o && csr_rdata_o == ent_data_i));

  p_single_request_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_req_o && ent_ack_i) |=> !ent_req_o);

  p_trigger_reads_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pref |-> (!csr_stall_o && csr_rdata_o == '0));

  p_fast_never_stalls_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fast |-> !csr_stall_o);
endmodule

bind rng_csr_unit rng_csr_unit_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csr_req_i   (csr_req_i),
  .csr_we_i    (csr_we_i),
  .csr_addr_i  (csr_addr_i),
  .csr_rdata_o (csr_rdata_o),
  .csr_stall_o (csr_stall_o),
  .ent_req_o   (ent_req_o),
  .ent_ack_i   (ent_ack_i),
  .ent_data_i  (ent_data_i)
);

// File: tb/test_rng_csr_unit.sv
`timescale 1ns/1ps
module test_rng_csr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_req = 1'b0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_rdata;
  logic        csr_stall;
  logic        ent_req;
  logic        ent_ack = 1'b0;
  logic [31:0] ent_data = '0;

  always #10 clk = ~clk;

  rng_csr_unit i_rng_csr_unit (
    .clk_i(clk), .rst_ni(rst_n), .csr_req_i(csr_req), .csr_we_i(csr_we),
    .csr_addr_i(csr_addr), .csr_rdata_o(csr_rdata), .csr_stall_o(csr_stall),
    .ent_req_o(ent_req), .ent_ack_i(ent_ack), .ent_data_i(ent_data)
  );

  typedef struct {
    logic [31:0] data;
    int          stalls;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0, n_bad = 0;
  int acks = 0, ack_delay = 1, wait_cnt = 0, seen_stalls = 0;
  logic [31:0] next_val = '0, spur_val = '0, model;
  bit spur_go = 0, done = 0;

  function automatic logic [31:0] prng_next(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'hA300_0000 : 32'h0);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // entropy responder
  always @(posedge clk) begin
    bit newack;
    #1;
    newack = 0;
    if (!rst_n) begin
      wait_cnt = 0;
    end else if (spur_go && !ent_req) begin
      newack = 1; ent_data = spur_val; spur_go = 0;
    end else if (ent_req && !ent_ack) begin
      wait_cnt++;
      if (wait_cnt >= ack_delay) begin
        newack = 1; ent_data = next_val; wait_cnt = 0; acks++;
      end
    end
    ent_ack = newack;
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && csr_req && !csr_we) begin
      if (csr_stall) seen_stalls++;
      else if (exp_q.size() == 0) check(0, "monitor unexpected read", csr_rdata, '0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(csr_rdata == e.data, e.tag, csr_rdata, e.data);
        check(seen_stalls == e.stalls, {e.tag, " stall count"}, 32'(seen_stalls), 32'(e.stalls));
        seen_stalls = 0;
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input int stalls, input string tag);
    exp_t e;
    e.data = exp; e.stalls = stalls; e.tag = tag;
    exp_q.push_back(e);
    csr_req = 1; csr_we = 0; csr_addr = a;
    do @(negedge clk); while (csr_stall);
    @(posedge clk); #1;
    csr_req = 0;
  endtask

  task automatic wr(input logic [11:0] a);
    csr_req = 1; csr_we = 1; csr_addr = a;
    @(posedge clk); #1;
    csr_req = 0; csr_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic fast_rd(input string tag);
    rd(12'hFC1, model, 0, tag);
    model = prng_next(model);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int a0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(1);
    // R1 reset state
    check(ent_req == 0, "R1 request low", 32'(ent_req), 0);
    check(csr_stall == 0, "R1 stall low", 32'(csr_stall), 0);
    check(csr_rdata == 0, "R1 rdata zero", csr_rdata, 0);

    // R8 fast register sequence
    model = 32'h1D87_2B41;
    fast_rd("R8 fast seed");
    fast_rd("R8 fast step1");
    fast_rd("R8 fast step2");

    // R2 R3 miss on empty cache
    ack_delay = 3; next_val = 32'hA5A5_0001;
    rd(12'hFC0, 32'hA5A5_0001, 3, "R2 R3 empty read");
    idle(1);
    check(ent_req == 0, "R3 request dropped", 32'(ent_req), 0);

    // R4 prefetch, R6 full cache
    ack_delay = 2; next_val = 32'hB0B0_0002; a0 = acks;
    wr(12'h7D8);
    idle(4);
    check(acks == a0 + 1, "R4 one fill", 32'(acks - a0), 1);
    check(ent_req == 0, "R6 request idle after fill", 32'(ent_req), 0);
    wr(12'h7D8);
    idle(3);
    check(ent_req == 0 && acks == a0 + 1, "R6 trigger on full cache", 32'(acks - a0), 1);
    rd(12'hFC0, 32'hB0B0_0002, 0, "R4 hit read");
    ack_delay = 1; next_val = 32'hC0C0_0003;
    rd(12'hFC0, 32'hC0C0_0003, 1, "R5 emptied after read");

    // R6 trigger while pending
    ack_delay = 3; next_val = 32'hD0D0_0004; a0 = acks;
    wr(12'h7D8);
    wr(12'h7D8);
    idle(6);
    check(acks == a0 + 1, "R6 single request while pending", 32'(acks - a0), 1);
    rd(12'hFC0, 32'hD0D0_0004, 0, "R6 stored word");

    // R3 read while fill outstanding
    ack_delay = 2; next_val = 32'hE0E0_0005;
    wr(12'h7D8);
    rd(12'hFC0, 32'hE0E0_0005, 1, "R3 read during fill");

    // R7 and R10
    rd(12'h7D8, 32'h0, 0, "R7 trigger reads zero");
    rd(12'h123, 32'h0, 0, "R10 unmapped read");
    fast_rd("R8 fast step3");

    // R9 stray acknowledge
    spur_val = 32'hF0F0_0006; spur_go = 1;
    idle(3);
    check(ent_req == 0, "R9 no request after stray ack", 32'(ent_req), 0);
    ack_delay = 1; next_val = 32'h1234_0007;
    rd(12'hFC0, 32'h1234_0007, 1, "R9 stray word not stored");
    fast_rd("R8 fast step4");

    idle(2);
    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule